// File: doc/BRIEF.md
# Prioritised Board Interrupt Combiner

This block gathers the interrupt sources of a processor board and turns them into a 15-bit request vector for a CPU with seven-level, 68k-style interrupt priorities. Each priority level that the board uses owns one bit of the vector. The CPU's own priority encoder and its acknowledge cycle sit outside the block.

Three byte-wide registers sit on a simple CPU bus. The source-enable register is at address 0 and the source-pending register is at address 1. A write to address 2 sets pending bits without clearing any. Bit 0 of the enable register plays two roles. It gates every request, including those from sources wired directly to the block, and it also enables the level-1 pending source.

Several sources bypass the pending register:
- a vertical-blank line from the video controller;
- a floppy interrupt, together with its enable bit;
- timer pending and timer enable;
- keyboard-received and keyboard enable.

A SCSI interrupt level drives pending bit 1. The four pending sources reach the levels in a scrambled order, which the requirements below set out.

Top module: `irq_combiner`

## Requirements
- R1: The enable and pending registers are 4 bits wide, and a write keeps only the low 4 bits of the data. Reads at address 0 and 1 return the register in bits 3:0 and zero in bits 7:4.
- R2: While enable bit 0 is clear, every bit of the request vector is 0, whatever the state of the direct inputs.
- R3: With enable bit 0 set, each bit of (enable AND pending) drives one request bit: bit 0 drives level 1 (vector bit 0), bit 1 drives level 4 (vector bit 7), bit 2 drives level 2 (vector bit 3) and bit 3 drives level 6 (vector bit 13). All other vector bits stay 0.
- R4: A write to address 2 ORs its low 4 data bits into the pending register. A read of address 2, or of address 3, returns zero.
- R5: The vertical-blank input requests level 3 (vector bit 4) whenever enable bit 0 is set. It has no pending bit.
- R6: The floppy input requests level 5 (vector bit 12) only when the floppy-enable input is also high and enable bit 0 is set.
- R7: With enable bit 0 set, timer pending AND timer enable requests level 1 (vector bit 0). Keyboard-received AND keyboard enable also requests level 1.
- R8: A rise of the SCSI input sets pending bit 1 and a fall clears it. If a bus write arrives in the same cycle, the SCSI change wins for that bit.
- R9: The request vector is registered. A change on a direct input shows at the output after one clock edge; a register write shows one edge after the register updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 enable, 1 pending, 2 force-set, 3 unused |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational |
| vblank_in | input | 1 | Video vertical-blank request |
| fdc_irq_in | input | 1 | Floppy interrupt |
| fdc_en_in | input | 1 | Floppy interrupt enable |
| scsi_irq_in | input | 1 | SCSI interrupt level |
| tmr_pend_in | input | 1 | Timer pending |
| tmr_en_in | input | 1 | Timer enable |
| kbd_rcv_in | input | 1 | Keyboard byte received |
| kbd_en_in | input | 1 | Keyboard interrupt enable |
| irq_vec_o | output | VEC_W | Registered level-request vector |

## Verification
The bench builds the block with its default parameters: an 8-bit bus, a 15-bit vector, and level bits at positions 0, 3, 4, 7, 12 and 13. Under these values every level position lies inside the vector, so each mapped bit and the zero bits between them can be observed at once. The table walks each pending bit in isolation and the combination of all four. It also covers the masking of pending bits by their enables, and each direct source with and without its own enable. Directed cases cover the master gate against all sources at once, the force-set merge, SCSI edges, and the one-edge output latency.

// File: rtl/irq_combiner.sv
module irq_combiner #(
  parameter int DATA_W = 8,
  parameter int VEC_W  = 15,
  parameter int L1_BIT = 0,
  parameter int L2_BIT = 3,
  parameter int L3_BIT = 4,
  parameter int L4_BIT = 7,
  parameter int L5_BIT = 12,
  parameter int L6_BIT = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              vblank_in,
  input  logic              fdc_irq_in,
  input  logic              fdc_en_in,
  input  logic              scsi_irq_in,
  input  logic              tmr_pend_in,
  input  logic              tmr_en_in,
  input  logic              kbd_rcv_in,
  input  logic              kbd_en_in,
  output logic [VEC_W-1:0]  irq_vec_o
);
  localparam int SRC_W = 4;

  logic [SRC_W-1:0] en_r, pend_r, pend_nx;
  logic             scsi_q;
  logic [VEC_W-1:0] req;

  wire wr_en    = bus_sel & bus_we & (bus_addr == 2'd0);
  wire wr_pend  = bus_sel & bus_we & (bus_addr == 2'd1);
  wire wr_force = bus_sel & bus_we & (bus_addr == 2'd2);
  wire [SRC_W-1:0] hit = en_r & pend_r;

  always_comb begin
    pend_nx = pend_r;
    if (wr_pend)  pend_nx = bus_wdata[SRC_W-1:0];
    if (wr_force) pend_nx = pend_nx | bus_wdata[SRC_W-1:0];
    if (scsi_irq_in != scsi_q) pend_nx[1] = scsi_irq_in;
  end

  always_comb begin
    req = '0;
    if (en_r[0]) begin
      req[L1_BIT] = req[L1_BIT] | hit[0] | (tmr_pend_in & tmr_en_in) | (kbd_rcv_in & kbd_en_in);
      req[L4_BIT] = req[L4_BIT] | hit[1];
      req[L2_BIT] = req[L2_BIT] | hit[2];
      req[L6_BIT] = req[L6_BIT] | hit[3];
      req[L3_BIT] = req[L3_BIT] | vblank_in;
      req[L5_BIT] = req[L5_BIT] | (fdc_irq_in & fdc_en_in);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_r      <= '0;
      pend_r    <= '0;
      scsi_q    <= 1'b0;
      irq_vec_o <= '0;
    end else begin
      if (wr_en) en_r <= bus_wdata[SRC_W-1:0];
      pend_r    <= pend_nx;
      scsi_q    <= scsi_irq_in;
      irq_vec_o <= req;
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = DATA_W'(en_r);
      2'd1:    bus_rdata = DATA_W'(pend_r);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_combiner_chk.sv
module irq_combiner_chk #(
  parameter int DATA_W = 8,
  parameter int VEC_W  = 15,
  parameter int L3_BIT = 4,
  parameter int L5_BIT = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [1:0]        bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              vblank_in,
  input logic              fdc_en_in,
  input logic              scsi_irq_in,
  input logic              scsi_q,
  input logic [3:0]        en_r,
  input logic [3:0]        pend_r,
  input logic [VEC_W-1:0]  irq_vec_o
);
  assert_master_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_r[0] |=> (irq_vec_o == '0));

  assert_read_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr[1] == 1'b0) |-> (bus_rdata[DATA_W-1:4] == '0));

  assert_force_merges_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == 2'd2 && scsi_irq_in == scsi_q)
      |=> ((pend_r & $past(bus_wdata[3:0])) == $past(bus_wdata[3:0])));

  assert_force_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[1] == 1'b1) |-> (bus_rdata == '0));

  assert_vblank_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_r[0] && vblank_in) |=> irq_vec_o[L3_BIT]);

  assert_fdc_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fdc_en_in |=> !irq_vec_o[L5_BIT]);

  assert_scsi_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (scsi_irq_in && !scsi_q) |=> pend_r[1]);

  assert_scsi_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!scsi_irq_in && scsi_q) |=> !pend_r[1]);
endmodule

bind irq_combiner irq_combiner_chk #(
  .DATA_W(DATA_W), .VEC_W(VEC_W), .L3_BIT(L3_BIT), .L5_BIT(L5_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .vblank_in(vblank_in), .fdc_en_in(fdc_en_in), .scsi_irq_in(scsi_irq_in),
  .scsi_q(scsi_q), .en_r(en_r), .pend_r(pend_r), .irq_vec_o(irq_vec_o)
);

// File: tb/irq_combiner_test.sv
module irq_combiner_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_sel = 0, bus_we = 0;
  logic [1:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        vblank_in = 0, fdc_irq_in = 0, fdc_en_in = 0, scsi_irq_in = 0;
  logic        tmr_pend_in = 0, tmr_en_in = 0, kbd_rcv_in = 0, kbd_en_in = 0;
  logic [14:0] irq_vec_o;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_combiner uut (.*);

  // {enable, pending, vb, fdc, fdc_en, tmr_p, tmr_e, kbd_r, kbd_e, expected}
  localparam int NV = 15;
  localparam logic [29:0] VEC [NV] = '{
    {4'h0, 4'hF, 7'b1111111, 15'h0000},  // R2 gate off, all sources
    {4'h1, 4'h1, 7'b0000000, 15'h0001},  // R3 bit0 -> L1
    {4'h3, 4'h2, 7'b0000000, 15'h0080},  // R3 bit1 -> L4
    {4'h5, 4'h4, 7'b0000000, 15'h0008},  // R3 bit2 -> L2
    {4'h9, 4'h8, 7'b0000000, 15'h2000},  // R3 bit3 -> L6
    {4'hF, 4'hF, 7'b0000000, 15'h2089},  // R3 all
    {4'h1, 4'hE, 7'b0000000, 15'h0000},  // R3 masked pendings
    {4'h1, 4'h0, 7'b1000000, 15'h0010},  // R5 vblank
    {4'h1, 4'h0, 7'b0100000, 15'h0000},  // R6 fdc without enable
    {4'h1, 4'h0, 7'b0110000, 15'h1000},  // R6 fdc enabled
    {4'h1, 4'h0, 7'b0001100, 15'h0001},  // R7 timer
    {4'h1, 4'h0, 7'b0001000, 15'h0000},  // R7 timer not enabled
    {4'h1, 4'h0, 7'b0000011, 15'h0001},  // R7 keyboard
    {4'h1, 4'h0, 7'b0000010, 15'h0000},  // R7 keyboard not enabled
    {4'h0, 4'h0, 7'b1000000, 15'h0000}   // R2 vblank gated
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic direct(logic [6:0] s);
    {vblank_in, fdc_irq_in, fdc_en_in, tmr_pend_in, tmr_en_in, kbd_rcv_in, kbd_en_in} = s;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9 reset vector", 32'(irq_vec_o), 0);
    rd(0, d); check("R1 reset enable", 32'(d), 0);
    rd(1, d); check("R1 reset pending", 32'(d), 0);

    for (int i = 0; i < NV; i++) begin
      wr(1, {4'h0, VEC[i][25:22]});
      wr(0, {4'h0, VEC[i][29:26]});
      direct(VEC[i][21:15]);
      @(negedge clk); @(negedge clk);
      check($sformatf("R2/R3/R5/R6/R7 vector %0d", i), 32'(irq_vec_o), 32'(VEC[i][14:0]));
    end
    direct('0);

    wr(0, 8'hFF); rd(0, d); check("R1 enable upper bits dropped", 32'(d), 32'h0F);
    wr(1, 8'hA1); rd(1, d); check("R1 pending upper bits dropped", 32'(d), 32'h01);
    wr(2, 8'hF4); rd(1, d); check("R4 force ORs into pending", 32'(d), 32'h05);
    rd(2, d); check("R4 force reads zero", 32'(d), 0);
    rd(3, d); check("R4 address 3 reads zero", 32'(d), 0);

    wr(1, 8'h00); wr(0, 8'h03);
    @(negedge clk); scsi_irq_in = 1;
    @(negedge clk); @(negedge clk);
    rd(1, d); check("R8 scsi rise sets pending bit 1", 32'(d), 32'h02);
    check("R8 scsi routes to level 4", 32'(irq_vec_o), 32'h0080);
    @(negedge clk); scsi_irq_in = 0;
    @(negedge clk); @(negedge clk);
    rd(1, d); check("R8 scsi fall clears pending bit 1", 32'(d), 0);
    check("R8 level 4 drops", 32'(irq_vec_o), 0);

    wr(0, 8'h01);
    @(negedge clk); vblank_in = 1;
    #1 check("R9 no change before edge", 32'(irq_vec_o), 0);
    @(negedge clk);
    check("R9 visible after one edge", 32'(irq_vec_o), 32'h0010);
    vblank_in = 0;
    wr(0, 8'h00);
    @(negedge clk);
    check("R2 gate cleared", 32'(irq_vec_o), 0);

    finish_run();
  end
endmodule